// File: doc/BRIEF.md
# Multi-rate clock and enable generator

This block derives a family of slower rates from one 32 MHz master clock. A free-running 5-bit binary counter supplies square waves at 16, 8, 4, 2 and 1 MHz. Each square wave is a bare counter flip-flop, so no combinational decode can put a glitch on it. Each rate also has a matching one-cycle clock-enable pulse, so that logic inside the chip can stay on the master clock and need not be clocked by a derived rate.

A CPU clock output carries one of the 16, 8 or 4 MHz rates, chosen by a two-bit speed input. The choice is made in a tree of 2:1 multiplexers. A final flip-flop sits on the master clock, so the pin is driven by a register. The selection inputs pass through a two-stage synchroniser. A new choice is applied only when the binary counter wraps to zero, because at that instant every selectable rate is low and no runt pulse can appear.

For single-stepping a system by eye, a debug prescaler is built from two chained modulo-N counters. With the default N of 1000, it turns the 2 MHz enable into a 2 kHz rate and then a 2 Hz rate. A debug-mode input routes the slowest rate to the CPU clock output, under the same synchronise-then-wrap rule.

Top module: `clkrate_gen`

## Requirements
- R1: `rate_sq[i]` is bit i of a 5-bit counter that counts up by one on every master clock and wraps from 31 to 0. Index 0 is 16 MHz, 1 is 8 MHz, 2 is 4 MHz, 3 is 2 MHz and 4 is 1 MHz, so bit i has a period of 2^(i+1) master cycles.
- R2: After reset is released, `rate_sq[0]` goes high on the first master clock edge. From then on it changes level on every edge.
- R3: `rate_en[i]` is high for exactly one master cycle in each period of `rate_sq[i]`. That cycle is the one in which `rate_sq[i]` has just gone from 0 to 1, which is the cycle where the counter modulo 2^(i+1) equals 2^i.
- R4: The effective speed code chooses the CPU rate: 2'b00 gives counter bit 0 (16 MHz), 2'b01 gives bit 1 (8 MHz), and 2'b10 or 2'b11 gives bit 2 (4 MHz). `cpu_clk` is the chosen bit registered once, so it lags that bit by one master cycle.
- R5: `cpu_speed` and `dbg_mode` each pass through two synchroniser flip-flops. The effective selection takes the synchronised value only at the edge where the counter goes from 31 to 0. Between those edges, changes to the inputs have no effect on `cpu_clk`.
- R6: The first debug stage keeps a modulo-`DEC_MOD` count that advances once per `rate_en[3]` pulse. When an advance leaves the count at `DEC_MOD/2-1` or at `DEC_MOD-1`, `dbg_khz_sq` changes level. `dbg_khz_en` is high for the single cycle in which `dbg_khz_sq` has just risen.
- R7: The second debug stage behaves like the first, but it advances once per `dbg_khz_en` pulse. It drives `dbg_hz_sq` and `dbg_hz_en`.
- R8: When the effective debug flag is 1, `cpu_clk` is `dbg_hz_sq` delayed by one master cycle, and the speed code has no effect. The flag follows the synchronise-and-wrap rule of R5.
- R9: A synchronous active-high `rst` clears every counter, the synchroniser, the effective selection and all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32 MHz master clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_speed | input | 2 | CPU rate code (00 = 16 MHz, 01 = 8 MHz, 1x = 4 MHz) |
| dbg_mode | input | 1 | Route the slowest debug rate to the CPU clock |
| rate_sq | output | 5 | Square waves 16/8/4/2/1 MHz, index 0 fastest |
| rate_en | output | 5 | One-cycle enables aligned to the rise of each square wave |
| dbg_khz_sq | output | 1 | First debug stage square wave (2 kHz by default) |
| dbg_khz_en | output | 1 | Enable pulse on the rise of `dbg_khz_sq` |
| dbg_hz_sq | output | 1 | Second debug stage square wave (2 Hz by default) |
| dbg_hz_en | output | 1 | Enable pulse on the rise of `dbg_hz_sq` |
| cpu_clk | output | 1 | Registered, selectable CPU clock |

## Verification
Two events can land in the same master cycle. One is the synchroniser handing over a new speed or debug choice. The other is the counter wrap that applies that choice. If the design gets the order wrong, one cycle of the old or the new rate is cut short. The bench changes the select inputs at every one of the 32 counter phases in turn, so the synchronised value sometimes arrives exactly on the wrap edge and sometimes one cycle before or after it. A behavioural model that applies a choice only at the wrap judges `cpu_clk` in every cycle, together with the debug rates that reach it in debug mode.

// File: rtl/clkrate_pkg.sv
package clkrate_pkg;

  // Effective CPU clock selection: speed code plus debug override.
  typedef struct packed {
    logic [1:0] speed;
    logic       dbg;
  } cpu_sel_t;

  // True when a counter value is the first one with bit idx set after a
  // run where it was clear: bit idx is 1 and all lower bits are 0.
  function automatic logic tap_rises(input logic [31:0] nxt, input int unsigned idx);
    logic [31:0] mask;
    mask = (32'd2 << idx) - 32'd1;
    return (nxt & mask) == (32'd1 << idx);
  endfunction

  // Half-period points of a modulo counter with a 50% duty output.
  function automatic logic half_point(input int unsigned cur, input int unsigned modv);
    return (cur == (modv / 2) - 1) || (cur == modv - 1);
  endfunction

  // Two-input multiplexer used as the building cell of the rate tree.
  function automatic logic pick2(input logic a, input logic b, input logic s);
    return s ? b : a;
  endfunction

endpackage

// File: rtl/clkrate_bindiv.sv
module clkrate_bindiv
  import clkrate_pkg::*;
#(
  parameter int unsigned DIV_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  output logic [DIV_W-1:0] count,
  output logic [DIV_W-1:0] en,
  output logic             wrap_next
);

  logic [DIV_W-1:0] count_nxt;

  assign count_nxt = count + 1'b1;
  assign wrap_next = (count == {DIV_W{1'b1}});

  always_ff @(posedge clk) begin
    if (rst) count <= '0;
    else     count <= count_nxt;
  end

  for (genvar i = 0; i < DIV_W; i++) begin : g_tap
    always_ff @(posedge clk) begin
      if (rst) en[i] <= 1'b0;
      else     en[i] <= tap_rises(32'(count_nxt), i);
    end

    assert_en_on_rise_R3: assert property (@(posedge clk) disable iff (rst)
      en[i] |-> $rose(count[i]));
    assert_rise_has_en_R3: assert property (@(posedge clk) disable iff (rst)
      $rose(count[i]) |-> en[i]);
    assert_en_single_R3: assert property (@(posedge clk) disable iff (rst)
      en[i] |=> !en[i]);
  end

  assert_fast_tap_low_R2: assert property (@(posedge clk) disable iff (rst)
    !count[0] |=> count[0]);
  assert_fast_tap_high_R2: assert property (@(posedge clk) disable iff (rst)
    count[0] |=> !count[0]);

endmodule

// File: rtl/clkrate_decdiv.sv
module clkrate_decdiv
  import clkrate_pkg::*;
#(
  parameter int unsigned MOD = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic adv,
  output logic sq,
  output logic pulse
);

  localparam int unsigned CW = (MOD > 2) ? $clog2(MOD) : 1;

  logic [CW-1:0] cnt;
  logic          at_half;
  logic          at_last;

  assign at_half = half_point(32'(cnt), MOD);
  assign at_last = (cnt == CW'(MOD - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      sq    <= 1'b0;
      pulse <= 1'b0;
    end else begin
      pulse <= 1'b0;
      if (adv) begin
        cnt <= at_last ? '0 : cnt + 1'b1;
        if (at_half) begin
          sq    <= ~sq;
          pulse <= ~sq;
        end
      end
    end
  end

  assert_count_in_range_R6: assert property (@(posedge clk) disable iff (rst)
    32'(cnt) < MOD);
  assert_pulse_on_rise_R7: assert property (@(posedge clk) disable iff (rst)
    pulse |-> $rose(sq));
  assert_rise_has_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(sq) |-> pulse);
  assert_idle_holds_R6: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(sq) && $stable(cnt));

endmodule

// File: rtl/clkrate_selsync.sv
module clkrate_selsync
  import clkrate_pkg::*;
#(
  parameter int unsigned SYNC_N = 2
) (
  input  logic     clk,
  input  logic     rst,
  input  logic [1:0] speed_in,
  input  logic     dbg_in,
  input  logic     wrap,
  output cpu_sel_t act
);

  cpu_sel_t stage [SYNC_N];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < SYNC_N; k++) stage[k] <= '0;
      act <= '0;
    end else begin
      stage[0] <= cpu_sel_t'{speed: speed_in, dbg: dbg_in};
      for (int k = 1; k < SYNC_N; k++) stage[k] <= stage[k-1];
      if (wrap) act <= stage[SYNC_N-1];
    end
  end

  assert_switch_at_wrap_R5: assert property (@(posedge clk) disable iff (rst)
    !$stable(act) |-> $past(wrap));

endmodule

// File: rtl/clkrate_cpumux.sv
module clkrate_cpumux
  import clkrate_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  cpu_sel_t act,
  input  logic     t16,
  input  logic     t8,
  input  logic     t4,
  input  logic     tdbg,
  output logic     cpu_clk
);

  logic lvl_fast;
  logic lvl_speed;
  logic lvl_final;

  assign lvl_fast  = pick2(t16, t8, act.speed[0]);
  assign lvl_speed = pick2(lvl_fast, t4, act.speed[1]);
  assign lvl_final = pick2(lvl_speed, tdbg, act.dbg);

  always_ff @(posedge clk) begin
    if (rst) cpu_clk <= 1'b0;
    else     cpu_clk <= lvl_final;
  end

endmodule

// File: rtl/clkrate_gen.sv
module clkrate_gen
  import clkrate_pkg::*;
#(
  parameter int unsigned DIV_W   = 5,
  parameter int unsigned DEC_MOD = 1000,
  parameter int unsigned SYNC_N  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       cpu_speed,
  input  logic             dbg_mode,
  output logic [DIV_W-1:0] rate_sq,
  output logic [DIV_W-1:0] rate_en,
  output logic             dbg_khz_sq,
  output logic             dbg_khz_en,
  output logic             dbg_hz_sq,
  output logic             dbg_hz_en,
  output logic             cpu_clk
);

  localparam int unsigned N_DEC  = 2;
  localparam int unsigned TAP_2M = DIV_W - 2;

  logic [DIV_W-1:0] count;
  logic             wrap_next;
  logic [N_DEC:0]   dec_adv;
  logic [N_DEC-1:0] dec_sq;
  cpu_sel_t         act;

  clkrate_bindiv #(.DIV_W(DIV_W)) u_bindiv (
    .clk       (clk),
    .rst       (rst),
    .count     (count),
    .en        (rate_en),
    .wrap_next (wrap_next)
  );

  assign rate_sq    = count;
  assign dec_adv[0] = rate_en[TAP_2M];

  for (genvar s = 0; s < N_DEC; s++) begin : g_dec
    clkrate_decdiv #(.MOD(DEC_MOD)) u_decdiv (
      .clk   (clk),
      .rst   (rst),
      .adv   (dec_adv[s]),
      .sq    (dec_sq[s]),
      .pulse (dec_adv[s+1])
    );
  end

  assign dbg_khz_sq = dec_sq[0];
  assign dbg_khz_en = dec_adv[1];
  assign dbg_hz_sq  = dec_sq[1];
  assign dbg_hz_en  = dec_adv[2];

  clkrate_selsync #(.SYNC_N(SYNC_N)) u_selsync (
    .clk      (clk),
    .rst      (rst),
    .speed_in (cpu_speed),
    .dbg_in   (dbg_mode),
    .wrap     (wrap_next),
    .act      (act)
  );

  clkrate_cpumux u_cpumux (
    .clk     (clk),
    .rst     (rst),
    .act     (act),
    .t16     (count[0]),
    .t8      (count[1]),
    .t4      (count[2]),
    .tdbg    (dec_sq[1]),
    .cpu_clk (cpu_clk)
  );

  assert_cpu_follows_16_R4: assert property (@(posedge clk) disable iff (rst)
    (act == cpu_sel_t'(3'b000) && $past(act) == act) |-> cpu_clk == $past(count[0]));
  assert_cpu_follows_dbg_R8: assert property (@(posedge clk) disable iff (rst)
    (act.dbg && $past(act.dbg)) |-> cpu_clk == $past(dec_sq[1]));
  assert_khz_steps_on_2m_R6: assert property (@(posedge clk) disable iff (rst)
    !$stable(dec_sq[0]) |-> $past(rate_en[TAP_2M]));
  assert_wrap_after_max_R1: assert property (@(posedge clk) disable iff (rst)
    wrap_next |=> count == '0);

endmodule

// File: tb/clkrate_gen_bench.sv
module clkrate_gen_bench;

  localparam int DM = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] spd = 2'b00;
  logic       dbg = 1'b0;
  logic [4:0] rate_sq, rate_en;
  logic       khz_sq, khz_en, hz_sq, hz_en, cpu_clk;

  clkrate_gen #(.DIV_W(5), .DEC_MOD(DM), .SYNC_N(2)) u_clkrate_gen (
    .clk (clk), .rst (rst), .cpu_speed (spd), .dbg_mode (dbg),
    .rate_sq (rate_sq), .rate_en (rate_en),
    .dbg_khz_sq (khz_sq), .dbg_khz_en (khz_en),
    .dbg_hz_sq (hz_sq), .dbg_hz_en (hz_en), .cpu_clk (cpu_clk)
  );

  always #4 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;

  // Behavioural reference state
  int m_cnt = 0, m_kc = 0, m_hc = 0;
  int m_khz = 0, m_khz_en = 0, m_hz = 0, m_hz_en = 0, m_cpu = 0;
  int m_act_spd = 0, m_act_dbg = 0;
  int sync_q[$];

  function automatic int rate_of(int sp, int dg, int c, int h);
    if (dg != 0) return h;
    if (sp == 0) return c % 2;
    if (sp == 1) return (c / 2) % 2;
    return (c / 4) % 2;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_kc = 0; m_hc = 0; m_khz = 0; m_khz_en = 0;
      m_hz = 0; m_hz_en = 0; m_cpu = 0; m_act_spd = 0; m_act_dbg = 0;
      sync_q = '{0, 0};
    end else begin
      int old_cnt, old_hz, old_khz_en, head;
      old_cnt = m_cnt; old_hz = m_hz; old_khz_en = m_khz_en;
      m_hz_en = 0;
      if (old_khz_en != 0) begin
        if (m_hc == DM/2 - 1 || m_hc == DM - 1) begin m_hz_en = 1 - m_hz; m_hz = 1 - m_hz; end
        m_hc = (m_hc + 1) % DM;
      end
      m_khz_en = 0;
      if (old_cnt % 16 == 8) begin
        if (m_kc == DM/2 - 1 || m_kc == DM - 1) begin m_khz_en = 1 - m_khz; m_khz = 1 - m_khz; end
        m_kc = (m_kc + 1) % DM;
      end
      m_cpu = rate_of(m_act_spd, m_act_dbg, old_cnt, old_hz);
      head = sync_q.pop_front();
      if (old_cnt == 31) begin m_act_spd = head / 2; m_act_dbg = head % 2; end
      sync_q.push_back(int'(spd) * 2 + int'(dbg));
      m_cnt = (old_cnt + 1) % 32;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R1 rate_sq", int'(rate_sq), m_cnt);
    for (int i = 0; i < 5; i++)
      chk("R3 rate_en", int'(rate_en[i]), ((m_cnt % (2 << i)) == (1 << i)) ? 1 : 0);
    chk("R6 dbg_khz_sq", int'(khz_sq), m_khz);
    chk("R6 dbg_khz_en", int'(khz_en), m_khz_en);
    chk("R7 dbg_hz_sq", int'(hz_sq), m_hz);
    chk("R7 dbg_hz_en", int'(hz_en), m_hz_en);
    chk("R4 R5 R8 cpu_clk", int'(cpu_clk), m_cpu);
  endtask

  task automatic run(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      compare_all();
    end
  endtask

  task automatic check_zero();
    chk("R9 reset rate_sq", int'(rate_sq), 0);
    chk("R9 reset rate_en", int'(rate_en), 0);
    chk("R9 reset debug", int'({khz_sq, khz_en, hz_sq, hz_en}), 0);
    chk("R9 reset cpu_clk", int'(cpu_clk), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_zero();
    rst = 1'b0;
    @(negedge clk);
    chk("R2 first edge rate_sq[0]", int'(rate_sq[0]), 1);
    compare_all();
    run(80);
    spd = 2'b01; run(90);
    spd = 2'b10; run(75);
    spd = 2'b11; run(50);
    spd = 2'b00; run(40);
    // R5: sweep select changes across every counter phase
    for (int ph = 0; ph < 32; ph++) begin
      spd = 2'(ph % 3);
      run(33 + ph);
    end
    // R8: debug route; speed changes are ignored meanwhile
    dbg = 1'b1; run(1700);
    spd = 2'b01; run(1800);
    dbg = 1'b0; run(120);
    // R9: reset in mid-run
    rst = 1'b1; run(3);
    check_zero();
    rst = 1'b0; run(400);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule